// File: doc/BRIEF.md
# External Interrupt Request Controller

This block watches a set of external interrupt request pins (eight by default) and turns the activity on each one into a latched status flag. Each line has its own sense setting that picks one of four trigger conditions: low level, falling edge, rising edge or either edge. A per-line enable bit decides whether a set flag takes part in the combined request to the processor. A lowest-index encoder reports which enabled line should be serviced first.

Software reaches the enable, status and sense settings through a small register bus with a combinational read path. A status flag can be cleared in only two ways. The first is a handshake: software reads the flag as 1 and then writes 0 to it. The second is a hardware acknowledge that carries the number of the line whose exception was taken. An acknowledge always clears the flag of an edge-triggered line. For a level-triggered line it clears the flag only while that line's synchronized input is high.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, all enable bits, status flags and sense settings are 0, so every line starts in low-level mode, and `irq_req` is 0.
- R2: `bus_rdata` shows the register chosen by `bus_addr` at all times, whether or not `bus_rd` is high. Address 0 is the enable register, with bit n for line n. Address 1 is the status register, with bit n for line n. Address 2 is the sense register, with line n in bits 2n+1:2n. Address 3 reads 0. Register bits above the lines read 0. A write with `bus_wr` to address 0 or 2 loads the register at the next clock edge.
- R3: `irq_req` is 1 exactly when at least one line has both its flag and its enable bit set. A disabled line still sets its flag but does not raise `irq_req`.
- R4: Each pin passes through two synchronizing flops. The sense codes are 00 for low level, 01 for falling edge, 10 for rising edge and 11 for both edges. An edge is found by comparing the synchronized value with its value one clock earlier. A pin change driven before clock edge k shows on the flag after edge k+2.
- R5: Writing 1 to a status bit never changes that flag. Writing 0 leaves the flag unchanged unless the flag was read as 1 by a status read after the most recent status write.
- R6: A status read with `bus_rd` arms each line whose flag reads 1. The next status write clears every armed line that is written 0. Every status write disarms all lines, whatever data it carries.
- R7: When `ack_valid` is high, the flag of line `ack_line` is cleared at the next clock edge if that line is in any edge mode.
- R8: When `ack_valid` is high for a line in low-level mode, its flag is cleared only if that line's synchronized input is high. Otherwise the flag stays set.
- R9: A set condition in the same cycle as a software or acknowledge clear wins, and the flag stays 1.
- R10: `pend_idx` gives the lowest-numbered line whose flag and enable bit are both set. It is 0 when there is no such line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin | input | N_LINES | External request pins, asynchronous |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms status clearing) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| ack_valid | input | 1 | Exception-taken acknowledge |
| ack_line | input | clog2(N_LINES) | Line number of the acknowledge |
| irq_req | output | 1 | Combined request to the processor |
| pend_idx | output | clog2(N_LINES) | Lowest enabled pending line |

## Verification
The bench targets the clear handshake in several cases. It writes 0 with no prior read, which a design without arming would clear. It writes 1 after a read, which a design that treats the data as a mask would clear. It writes 0 after an intervening write, which a design that keeps the arming would clear. It acknowledges a low-level line while its pin is still low, which a design that always clears on acknowledge would wrongly clear. It also sets and clears a line in the same cycle, where a design giving clear precedence would drop a live level request. Two lines become pending together to test the encoder's order, and a disabled flagged line must not raise the request. A long seeded random run against a cycle model in the bench covers the mixes of these cases and the exact synchronizer latency.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Per-line trigger selection, two bits per line in the sense register
    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_FALL = 2'b01,
        SNS_RISE = 2'b10,
        SNS_BOTH = 2'b11
    } sense_e;

    localparam int SENSE_W = 2;

    // Register bus addresses
    localparam logic [1:0] ADDR_EN     = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_SENSE  = 2'd2;

endpackage

// File: rtl/irq_sync.sv
module irq_sync
    import irq_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_LINES-1:0]         pin,
    input  logic [SENSE_W*N_LINES-1:0] sense,
    output logic [N_LINES-1:0]         level,
    output logic [N_LINES-1:0]         evt
);

    typedef struct packed {
        logic [N_LINES-1:0] s1;
        logic [N_LINES-1:0] s2;
        logic [N_LINES-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.s1   <= '1;
            st_q.s2   <= '1;
            st_q.prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.s2;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        sense_e mode;
        assign mode = sense_e'(sense[SENSE_W*i +: SENSE_W]);
        always_comb begin
            case (mode)
                SNS_LOW:  evt[i] = ~st_q.s2[i];
                SNS_FALL: evt[i] = st_q.prev[i] & ~st_q.s2[i];
                SNS_RISE: evt[i] = ~st_q.prev[i] & st_q.s2[i];
                default:  evt[i] = st_q.prev[i] ^ st_q.s2[i];
            endcase
        end

        // R4: an edge-mode event needs the synchronized level to have moved
        AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && mode != SNS_LOW) |-> (st_q.s2[i] != $past(st_q.s2[i]))); // R4
    end

endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_LINES-1:0]         evt,
    input  logic [N_LINES-1:0]         level,
    input  logic [SENSE_W*N_LINES-1:0] sense,
    input  logic                       rd_status,
    input  logic                       wr_status,
    input  logic [N_LINES-1:0]         wdata,
    input  logic                       ack_valid,
    input  logic [IW-1:0]              ack_line,
    output logic [N_LINES-1:0]         flags
);

    typedef struct packed {
        logic [N_LINES-1:0] flag;
        logic [N_LINES-1:0] arm;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        logic sw_clr;
        logic hw_clr;
        sense_e mode;
        st_d = st_q;
        if (rd_status) begin
            st_d.arm = st_q.flag;
        end
        if (wr_status) begin
            st_d.arm = '0;
        end
        for (int i = 0; i < N_LINES; i++) begin
            mode   = sense_e'(sense[SENSE_W*i +: SENSE_W]);
            sw_clr = wr_status && st_q.arm[i] && !wdata[i];
            hw_clr = ack_valid && (ack_line == IW'(i)) &&
                     ((mode != SNS_LOW) || level[i]);
            if (evt[i]) begin
                st_d.flag[i] = 1'b1;
            end else if (sw_clr || hw_clr) begin
                st_d.flag[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= '0;
            st_q.arm  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flag;

    AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_status) |-> (st_q.arm == '0)); // R6

    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(evt[i]) |-> st_q.flag[i]); // R9
        AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.flag[i]) |-> $past(evt[i])); // R5
        AST_FALL_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.flag[i]) |->
                $past((wr_status && st_q.arm[i] && !wdata[i]) ||
                      (ack_valid && ack_line == IW'(i)))); // R6
        AST_LEVEL_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && ack_line == IW'(i) && st_q.flag[i] && !level[i] &&
             sense[SENSE_W*i +: SENSE_W] == SNS_LOW && !wr_status)
                |=> st_q.flag[i]); // R8
    end

endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int N_LINES = 8,
    localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] active,
    output logic               any,
    output logic [IW-1:0]      idx
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (active[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 16,
    localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_pin,
    input  logic [1:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               ack_valid,
    input  logic [IW-1:0]      ack_line,
    output logic               irq_req,
    output logic [IW-1:0]      pend_idx
);

    localparam int SNS_BITS = SENSE_W * N_LINES;

    typedef struct packed {
        logic [N_LINES-1:0]  en;
        logic [SNS_BITS-1:0] sns;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [N_LINES-1:0] level;
    logic [N_LINES-1:0] evt;
    logic [N_LINES-1:0] flags;
    logic [N_LINES-1:0] active;
    logic               rd_status;
    logic               wr_status;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr && bus_addr == ADDR_EN) begin
            cfg_d.en = bus_wdata[N_LINES-1:0];
        end
        if (bus_wr && bus_addr == ADDR_SENSE) begin
            cfg_d.sns = bus_wdata[SNS_BITS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.en  <= '0;
            cfg_q.sns <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_status = bus_rd && (bus_addr == ADDR_STATUS);
    assign wr_status = bus_wr && (bus_addr == ADDR_STATUS);

    irq_sync #(.N_LINES(N_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (irq_pin),
        .sense (cfg_q.sns),
        .level (level),
        .evt   (evt)
    );

    irq_flags #(.N_LINES(N_LINES)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .level     (level),
        .sense     (cfg_q.sns),
        .rd_status (rd_status),
        .wr_status (wr_status),
        .wdata     (bus_wdata[N_LINES-1:0]),
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .flags     (flags)
    );

    assign active = flags & cfg_q.en;

    irq_pend #(.N_LINES(N_LINES)) u_pend (
        .active (active),
        .any    (irq_req),
        .idx    (pend_idx)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_EN:     bus_rdata[N_LINES-1:0]  = cfg_q.en;
            ADDR_STATUS: bus_rdata[N_LINES-1:0]  = flags;
            ADDR_SENSE:  bus_rdata[SNS_BITS-1:0] = cfg_q.sns;
            default:     bus_rdata = '0;
        endcase
    end

    logic [N_LINES-1:0] below_mask;
    assign below_mask = (N_LINES'(1) << pend_idx) - N_LINES'(1);

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.en == '0) |-> !irq_req); // R3
    AST_PEND_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flags[pend_idx] && cfg_q.en[pend_idx] &&
                     ((flags & cfg_q.en & below_mask) == '0))); // R10
    AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_EN) |=> (cfg_q.en == $past(bus_wdata[N_LINES-1:0]))); // R2

endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;

    localparam int N  = 8;
    localparam int DW = 16;
    localparam int IW = 3;
    localparam time HALF = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_pin = '1;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          ack_valid = 1'b0;
    logic [IW-1:0] ack_line = '0;
    logic          irq_req;
    logic [IW-1:0] pend_idx;

    int n_checks = 0;
    int n_fails  = 0;

    always #(HALF) clk = ~clk;

    irq_ctrl #(.N_LINES(N), .DATA_W(DW)) u_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .irq_req(irq_req), .pend_idx(pend_idx)
    );

    // Cycle model built from the requirements
    logic [N-1:0]   m_s1, m_s2, m_prev, m_flag, m_arm, m_en;
    logic [2*N-1:0] m_sns;

    always @(posedge clk) begin
        logic [N-1:0] nf;
        logic e, clr;
        logic [1:0] md;
        if (!rst_n) begin
            m_s1 <= '1; m_s2 <= '1; m_prev <= '1;
            m_flag <= '0; m_arm <= '0; m_en <= '0; m_sns <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                md = m_sns[2*i +: 2];
                case (md)
                    2'b00: e = !m_s2[i];
                    2'b01: e = m_prev[i] && !m_s2[i];
                    2'b10: e = !m_prev[i] && m_s2[i];
                    default: e = m_prev[i] != m_s2[i];
                endcase
                clr = (bus_wr && bus_addr == 2'd1 && m_arm[i] && !bus_wdata[i]) ||
                      (ack_valid && ack_line == IW'(i) && (md != 2'b00 || m_s2[i]));
                nf[i] = e ? 1'b1 : (clr ? 1'b0 : m_flag[i]);
            end
            m_flag <= nf;
            if (bus_wr && bus_addr == 2'd1) m_arm <= '0;
            else if (bus_rd && bus_addr == 2'd1) m_arm <= m_flag;
            if (bus_wr && bus_addr == 2'd0) m_en <= bus_wdata[N-1:0];
            if (bus_wr && bus_addr == 2'd2) m_sns <= bus_wdata;
            m_s1 <= irq_pin; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    function automatic logic [IW-1:0] exp_pend(input logic [N-1:0] v);
        logic [IW-1:0] r = '0;
        for (int i = N - 1; i >= 0; i--) if (v[i]) r = IW'(i);
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return DW'(m_en);
            2'd1: return DW'(m_flag);
            2'd2: return m_sns;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ack(input logic [IW-1:0] l);
        @(negedge clk);
        ack_line = l; ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        #1;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
        #1;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd20240531));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        peek(2'd0, d); check("R1 enable", d, 0);
        peek(2'd1, d); check("R1 status", d, 0);
        peek(2'd2, d); check("R1 sense", d, 0);
        check("R1 irq_req", irq_req, 0);
        // R2 register access, unused bits read 0
        bus_write(2'd0, 16'hFFA5); peek(2'd0, d); check("R2 enable", d, 16'h00A5);
        bus_write(2'd2, 16'h1234); peek(2'd2, d); check("R2 sense", d, 16'h1234);
        peek(2'd3, d); check("R2 addr3", d, 0);
        bus_write(2'd2, 16'h5555);
        // R4 falling edge on line 2, exact latency
        @(negedge clk); irq_pin[2] = 1'b0;
        wait_neg(2); peek(2'd1, d); check("R4 not yet", d, 0);
        wait_neg(1); peek(2'd1, d); check("R4 set", d, 16'h0004);
        check("R3 req", irq_req, 1); check("R10 idx", pend_idx, 2);
        // R5 write 0 with no prior read, write 1 after read
        bus_write(2'd1, 16'h0000); peek(2'd1, d); check("R5 unarmed 0", d, 16'h0004);
        bus_read(2'd1, d); check("R6 read", d, 16'h0004);
        bus_write(2'd1, 16'h00FF); peek(2'd1, d); check("R5 write 1", d, 16'h0004);
        // R6 arming consumed by the previous write
        bus_write(2'd1, 16'h0000); peek(2'd1, d); check("R6 disarmed", d, 16'h0004);
        bus_read(2'd1, d);
        bus_write(2'd1, 16'h0000); peek(2'd1, d); check("R6 clear", d, 0);
        // R10 two lines together; R7 edge ack
        @(negedge clk); irq_pin[2] = 1'b1; irq_pin[5] = 1'b0; irq_pin[0] = 1'b0;
        wait_neg(4); peek(2'd1, d); check("R4 two", d, 16'h0021);
        check("R10 lowest", pend_idx, 0);
        ack(3'd0); peek(2'd1, d); check("R7 edge ack", d, 16'h0020);
        check("R10 next", pend_idx, 5);
        // R8 level-mode acknowledge on line 6
        bus_write(2'd2, 16'h4555);
        @(negedge clk); irq_pin[6] = 1'b0;
        wait_neg(4); peek(2'd1, d); check("R4 level", d, 16'h0060);
        ack(3'd6); peek(2'd1, d); check("R8 pin low keeps", d, 16'h0060);
        @(negedge clk); irq_pin[6] = 1'b1;
        wait_neg(4);
        ack(3'd6); peek(2'd1, d); check("R8 pin high clears", d, 16'h0020);
        // R9 set wins over software clear
        @(negedge clk); irq_pin[6] = 1'b0;
        wait_neg(4);
        bus_read(2'd1, d);
        bus_write(2'd1, 16'h0000); peek(2'd1, d); check("R9 set wins", d, 16'h0040);
        // R3 disabled flagged line (enable bit 6 is 0)
        check("R3 disabled", irq_req, 0); check("R10 none", pend_idx, 0);
        // Random phase against the model
        for (int c = 0; c < 4000; c++) begin
            int op;
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0; ack_valid = 1'b0;
            if ($urandom % 6 == 0) irq_pin[$urandom % N] ^= 1'b1;
            if ($urandom % 8 == 0) begin ack_valid = 1'b1; ack_line = IW'($urandom % N); end
            op = int'($urandom % 16);
            bus_addr = 2'($urandom % 4);
            bus_wdata = DW'($urandom);
            if (op < 4) begin bus_addr = 2'd1; bus_rd = 1'b1; end
            else if (op < 6) begin bus_addr = 2'd1; bus_wr = 1'b1; end
            else if (op == 6) begin bus_addr = 2'd0; bus_wr = 1'b1; end
            else if (op == 7) begin bus_addr = 2'd2; bus_wr = 1'b1; end
            #1;
            check("R3 random req", irq_req, |(m_flag & m_en));
            check("R10 random idx", pend_idx, exp_pend(m_flag & m_en));
            check("R2 random rdata", bus_rdata, exp_rdata(bus_addr));
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; ack_valid = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule